// File: doc/BRIEF.md
# FIFO Trigger Controller for an Asynchronous Serial Port

This block sits between a host processor and the byte stream of one asynchronous serial port. It buffers outgoing bytes in a transmit FIFO and incoming bytes in a receive FIFO, each 128 entries deep. It raises two level-sensitive interrupt requests. The receive request fires when enough bytes are waiting. The transmit request fires when enough room is free. The bit-level serializer and deserializer are outside the block and appear only as byte handshakes: the receiver pushes a byte, and the transmitter takes the head byte with a pop strobe.

The threshold for each interrupt runs in one of two modes. In the legacy mode, selected after every reset, a two-bit code picks one of four fixed levels. In the extended mode, a per-direction byte register gives a level anywhere from 1 to the full depth. The host reaches the block through a small parallel register port. An access is taken only when the chip select is asserted low and the two most significant address bits are both zero. Any other pattern leaves the block deaf to writes and its read bus undriven.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: Each FIFO holds up to 128 bytes in arrival order. A host write to the data register (index 0) while the transmit FIFO holds 128 bytes is dropped. `tx_valid` is high exactly when the transmit FIFO is non-empty, and `tx_data` then shows its oldest byte. Count registers at index 5 (receive) and 6 (transmit) read back the occupancy.
- R2: After reset, both FIFOs are empty, the overrun flag is clear, the mode is legacy, both level codes are 00, and both programmable level registers read 1.
- R3: In legacy mode, the level codes are held in the control register (index 1): receive code in bits [5:4], transmit code in bits [7:6]. The codes 00, 01, 10 and 11 give levels of 8, 16, 56 and 60 bytes.
- R4: Control bit 0 set selects the extended mode. The receive level then comes from the register at index 2 and the transmit level from the register at index 3. A value of 0 acts as 1, and a value above 128 acts as 128.
- R5: `rx_irq` is high in any cycle where receive occupancy is at least the receive level, and low otherwise.
- R6: `tx_irq` is high in any cycle where transmit free space (128 minus occupancy) is at least the transmit level, and low otherwise.
- R7: An access is accepted only when `cs_n` is 0 and `addr[7:6]` is 00. Otherwise writes change nothing, and `rdata_oe` stays 0 with `rdata` at 0. When a read is accepted, `rdata_oe` is 1 in the same cycle.
- R8: When the receive side pushes into a full receive FIFO, the byte is dropped and a sticky overrun flag is set. The flag is status bit 0 (index 4). Reading the status register clears the flag on the following edge, unless a new overrun arrives in that same cycle. The other status bits are: bit 1 receive empty, bit 2 transmit full, bit 3 `rx_irq`, bit 4 `tx_irq`.
- R9: Writing the control register with bit 1 set empties the receive FIFO at the next edge. Writing it with bit 2 set empties the transmit FIFO at the next edge. Neither bit is stored, and mode and level settings are unchanged. A clear takes precedence over a push or pop in the same cycle.
- R10: Writing the control register with bit 3 set performs a software reset. It empties both FIFOs, clears the overrun flag, and returns the control register to legacy mode with both codes at 00. The programmable level registers keep their values.
- R11: An accepted read of the data register returns the oldest receive byte and removes it. If the receive FIFO is empty, the read returns 0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 8 | Host address; bits [7:6] qualify, bits [2:0] pick the register |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not driven |
| rdata_oe | output | 1 | Read bus drive enable |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_data | input | 8 | Byte from receiver |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit FIFO non-empty |
| rx_irq | output | 1 | Receive threshold request |
| tx_irq | output | 1 | Transmit threshold request |

## Verification
The interrupt outputs and the count registers are combinational views of the occupancy state. A corrupted pointer or count therefore shows in the same cycle as a wrong `tx_data`, a count readback that does not match, or an interrupt that crosses its threshold one byte early or late. A wrong mode or level decode shows only once occupancy reaches the boundary. For that reason the stimulus fills and drains across each of the four legacy levels and each extended corner value (0, 5, 128, above 128). The overrun flag and the FIFO clear bits are also checked on the edge right after the event that should set or clear them.

// File: rtl/fifo_trig_pkg.sv
// Shared constants and helpers for the FIFO trigger controller.
// Assumes the FIFO depth is at least the largest legacy level (60).
package fifo_trig_pkg;

    localparam logic [2:0] REG_DATA   = 3'd0;
    localparam logic [2:0] REG_CTRL   = 3'd1;
    localparam logic [2:0] REG_RX_LVL = 3'd2;
    localparam logic [2:0] REG_TX_LVL = 3'd3;
    localparam logic [2:0] REG_STATUS = 3'd4;
    localparam logic [2:0] REG_RX_CNT = 3'd5;
    localparam logic [2:0] REG_TX_CNT = 3'd6;

    // Stored part of the control register.
    typedef struct packed {
        logic [1:0] tx_code;
        logic [1:0] rx_code;
        logic       ext_mode;
    } ctrl_t;

    // Legacy fixed level from a two-bit code.
    function automatic int unsigned legacy_level(input logic [1:0] code);
        case (code)
            2'b00:   return 8;
            2'b01:   return 16;
            2'b10:   return 56;
            default: return 60;
        endcase
    endfunction

    // Effective threshold for either mode, clamped to 1..depth.
    function automatic int unsigned resolve_level(input logic ext, input logic [1:0] code,
                                                  input logic [7:0] prog, input int unsigned depth);
        if (!ext)
            return legacy_level(code);
        if (prog == 8'd0)
            return 1;
        if (32'(prog) > depth)
            return depth;
        return 32'(prog);
    endfunction

endpackage

// File: rtl/byte_fifo.sv
// Circular byte buffer with occupancy count and a synchronous clear.
// Push into a full buffer and pop from an empty one are ignored.
// Clear takes precedence over push and pop in the same cycle.
module byte_fifo #(
    parameter  int WIDTH = 8,
    parameter  int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    // Qualify the requests against the current fill state.
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !clr)
            mem[wr_ptr] <= din;
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/trig_unit.sv
// Threshold comparator for one interrupt direction.
// Compares a quantity (occupancy or free space) with the resolved level.
module trig_unit #(
    parameter  int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             ext_mode,
    input  logic [1:0]       code,
    input  logic [7:0]       prog,
    input  logic [CNT_W-1:0] amount,
    output logic             irq
);

    import fifo_trig_pkg::*;

    int unsigned level;

    // Pick the level for the active mode and compare.
    always_comb begin
        level = resolve_level(ext_mode, code, prog, DEPTH);
        irq   = (32'(amount) >= level);
    end

endmodule

// File: rtl/host_regs.sv
// Host register port: qualifies accesses by chip select and the two top
// address bits, holds control and level registers and the overrun flag,
// and drives the read mux. Assumes single-cycle strobes.
module host_regs #(
    parameter  int ADDR_W = 8,
    parameter  int DEPTH  = 128,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic                  rdata_oe,
    input  logic [7:0]            rx_head,
    input  logic                  rx_empty,
    input  logic                  rx_full,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic                  tx_full,
    input  logic [CNT_W-1:0]      tx_count,
    input  logic                  rx_irq,
    input  logic                  tx_irq,
    input  logic                  rx_push,
    output logic                  tx_push,
    output logic                  rx_pop,
    output logic                  rx_clr,
    output logic                  tx_clr,
    output fifo_trig_pkg::ctrl_t  ctrl,
    output logic [7:0]            rx_prog,
    output logic [7:0]            tx_prog,
    output logic                  overrun
);

    import fifo_trig_pkg::*;

    logic       selected;
    logic       wr_hit;
    logic       rd_hit;
    logic [2:0] idx;
    logic       ctrl_wr;
    logic       soft_rst;

    // Decode the access and derive the FIFO strobes.
    always_comb begin
        selected = !cs_n && (addr[ADDR_W-1 -: 2] == 2'b00);
        idx      = addr[2:0];
        wr_hit   = selected && wr_en;
        rd_hit   = selected && rd_en;
        ctrl_wr  = wr_hit && (idx == REG_CTRL);
        soft_rst = ctrl_wr && wdata[3];
        rx_clr   = ctrl_wr && (wdata[1] || wdata[3]);
        tx_clr   = ctrl_wr && (wdata[2] || wdata[3]);
        tx_push  = wr_hit && (idx == REG_DATA);
        rx_pop   = rd_hit && (idx == REG_DATA);
        rdata_oe = rd_hit;
    end

    // Control register: mode and legacy codes, restored by software reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.ext_mode <= wdata[0];
            ctrl.rx_code  <= wdata[5:4];
            ctrl.tx_code  <= wdata[7:6];
        end
    end

    // Programmable extended-mode levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prog <= 8'd1;
            tx_prog <= 8'd1;
        end else if (wr_hit) begin
            if (idx == REG_RX_LVL) rx_prog <= wdata;
            if (idx == REG_TX_LVL) tx_prog <= wdata;
        end
    end

    // Sticky overrun: set on a push into a full FIFO, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)
            overrun <= 1'b0;
        else if (rx_push && rx_full)
            overrun <= 1'b1;
        else if (rd_hit && (idx == REG_STATUS))
            overrun <= 1'b0;
    end

    // Read data mux; zero whenever the bus is not driven.
    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            case (idx)
                REG_DATA:   rdata = rx_empty ? 8'h00 : rx_head;
                REG_CTRL:   rdata = {ctrl.tx_code, ctrl.rx_code, 3'b000, ctrl.ext_mode};
                REG_RX_LVL: rdata = rx_prog;
                REG_TX_LVL: rdata = tx_prog;
                REG_STATUS: rdata = {3'b000, tx_irq, rx_irq, tx_full, rx_empty, overrun};
                REG_RX_CNT: rdata = 8'(rx_count);
                REG_TX_CNT: rdata = 8'(tx_count);
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/fifo_trig_ctrl.sv
// Top level: two byte FIFOs, two threshold comparators and the host port.
// The serializer side is a byte push (receive) and pop (transmit) handshake.
module fifo_trig_ctrl #(
    parameter  int ADDR_W = 8,
    parameter  int DEPTH  = 128,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    input  logic              rx_push,
    input  logic [7:0]        rx_data,
    input  logic              tx_pop,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              rx_irq,
    output logic              tx_irq
);

    import fifo_trig_pkg::*;

    ctrl_t            ctrl;
    logic [7:0]       rx_prog;
    logic [7:0]       tx_prog;
    logic             overrun;
    logic [7:0]       rx_head;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] tx_count;
    logic [CNT_W-1:0] tx_free;
    logic             rx_full;
    logic             rx_empty;
    logic             tx_full;
    logic             tx_empty;
    logic             tx_push;
    logic             rx_pop;
    logic             rx_clr;
    logic             tx_clr;

    // Free space feeds the transmit comparator.
    always_comb begin
        tx_free  = CNT_W'(DEPTH) - tx_count;
        tx_valid = !tx_empty;
    end

    host_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_full(rx_full), .rx_count(rx_count),
        .tx_full(tx_full), .tx_count(tx_count), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .rx_push(rx_push), .tx_push(tx_push), .rx_pop(rx_pop),
        .rx_clr(rx_clr), .tx_clr(tx_clr), .ctrl(ctrl),
        .rx_prog(rx_prog), .tx_prog(tx_prog), .overrun(overrun)
    );

    byte_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .din(rx_data), .pop(rx_pop),
        .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    byte_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .din(wdata), .pop(tx_pop),
        .dout(tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    trig_unit #(.DEPTH(DEPTH)) u_rx_trig (
        .ext_mode(ctrl.ext_mode), .code(ctrl.rx_code), .prog(rx_prog),
        .amount(rx_count), .irq(rx_irq)
    );

    trig_unit #(.DEPTH(DEPTH)) u_tx_trig (
        .ext_mode(ctrl.ext_mode), .code(ctrl.tx_code), .prog(tx_prog),
        .amount(tx_free), .irq(tx_irq)
    );

endmodule

// File: rtl/fifo_trig_ctrl_chk.sv
// Property checker for fifo_trig_ctrl, attached by bind below.
module fifo_trig_ctrl_chk #(
    parameter  int ADDR_W = 8,
    parameter  int DEPTH  = 128,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wdata,
    input logic              rdata_oe,
    input logic              rx_push,
    input logic              tx_pop,
    input logic              rx_irq,
    input logic              tx_irq,
    input logic [CNT_W-1:0]  rx_count,
    input logic [CNT_W-1:0]  tx_count,
    input logic              overrun
);

    logic sel_ok;
    assign sel_ok = !cs_n && (addr[ADDR_W-1 -: 2] == 2'b00);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_count) <= DEPTH) && (32'(tx_count) <= DEPTH));

    assert_oe_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> sel_ok);

    assert_unselected_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && !tx_pop) |=> $stable(tx_count));

    assert_rx_irq_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_irq);

    assert_rx_irq_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_count) == DEPTH) |-> rx_irq);

    assert_tx_irq_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |-> tx_irq);

    assert_overrun_on_full_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && (32'(rx_count) == DEPTH)) |=> overrun);

    assert_rx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ok && wr_en && (addr[2:0] == 3'd1) && wdata[1]) |=> (rx_count == '0));

endmodule

bind fifo_trig_ctrl fifo_trig_ctrl_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata_oe(rdata_oe), .rx_push(rx_push), .tx_pop(tx_pop), .rx_irq(rx_irq),
    .tx_irq(tx_irq), .rx_count(rx_count), .tx_count(tx_count), .overrun(overrun)
);

// File: tb/sim_fifo_trig_ctrl.sv
// Cycle-by-cycle reference model bench for fifo_trig_ctrl.
module sim_fifo_trig_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       rx_irq;
    logic       tx_irq;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string tag    = "R2";

    // Reference model state.
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit         m_ext = 0;
    logic [1:0] m_rc = 0, m_tc = 0;
    logic [7:0] m_rl = 1, m_tl = 1;
    bit         m_ovr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_trig_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .rx_push(rx_push),
        .rx_data(rx_data), .tx_pop(tx_pop), .tx_data(tx_data), .tx_valid(tx_valid),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    function automatic int lvl(bit ext, logic [1:0] code, logic [7:0] prog);
        int t[4] = '{8, 16, 56, 60};
        if (!ext) return t[code];
        if (prog == 0) return 1;
        if (prog > DEPTH) return DEPTH;
        return int'(prog);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s actual=%0d expected=%0d t=%0t", req, tag, what, act, exp, $time);
        end
    endtask

    // Drive one cycle, compare outputs, then advance the model.
    task automatic cyc(bit c, logic [7:0] a, bit w, bit r, logic [7:0] d, bit rp, logic [7:0] rdat, bit tp);
        bit sel, wa, ra, rclr, tclr, srst;
        int eri, eti, exp_rd;
        cs_n = c; addr = a; wr_en = w; rd_en = r; wdata = d;
        rx_push = rp; rx_data = rdat; tx_pop = tp;
        #1;
        sel = !c && (a[7:6] == 2'b00);
        wa = sel && w; ra = sel && r;
        eri = (rxq.size() >= lvl(m_ext, m_rc, m_rl)) ? 1 : 0;
        eti = ((DEPTH - txq.size()) >= lvl(m_ext, m_tc, m_tl)) ? 1 : 0;
        exp_rd = 0;
        if (ra) case (a[2:0])
            3'd0: exp_rd = rxq.size() > 0 ? int'(rxq[0]) : 0;
            3'd1: exp_rd = {m_tc, m_rc, 3'b000, m_ext};
            3'd2: exp_rd = m_rl;
            3'd3: exp_rd = m_tl;
            3'd4: exp_rd = {eti[0], eri[0], txq.size() == DEPTH, rxq.size() == 0, m_ovr};
            3'd5: exp_rd = rxq.size();
            3'd6: exp_rd = txq.size();
            default: exp_rd = 0;
        endcase
        chk("R7", "rdata_oe", int'(rdata_oe), int'(ra));
        chk(a[2:0] == 3'd4 ? "R8" : a[2:0] == 3'd0 ? "R11" : "R7", "rdata", int'(rdata), exp_rd);
        chk("R5", "rx_irq", int'(rx_irq), eri);
        chk("R6", "tx_irq", int'(tx_irq), eti);
        chk("R1", "tx_valid", int'(tx_valid), txq.size() > 0);
        if (txq.size() > 0) chk("R1", "tx_data", int'(tx_data), int'(txq[0]));
        // Advance model.
        srst = wa && a[2:0] == 3'd1 && d[3];
        rclr = wa && a[2:0] == 3'd1 && (d[1] || d[3]);
        tclr = wa && a[2:0] == 3'd1 && (d[2] || d[3]);
        if (srst) m_ovr = 0;
        else if (rp && rxq.size() == DEPTH) m_ovr = 1;
        else if (ra && a[2:0] == 3'd4) m_ovr = 0;
        if (rclr) rxq.delete();
        else begin
            bit full_now = (rxq.size() == DEPTH);
            if (ra && a[2:0] == 3'd0 && rxq.size() > 0) void'(rxq.pop_front());
            if (rp && !full_now) rxq.push_back(rdat);
        end
        if (tclr) txq.delete();
        else begin
            bit full_now = (txq.size() == DEPTH);
            if (tp && txq.size() > 0) void'(txq.pop_front());
            if (wa && a[2:0] == 3'd0 && !full_now) txq.push_back(d);
        end
        if (wa && a[2:0] == 3'd1) begin
            if (d[3]) begin m_ext = 0; m_rc = 0; m_tc = 0; end
            else begin m_ext = d[0]; m_rc = d[5:4]; m_tc = d[7:6]; end
        end
        if (wa && a[2:0] == 3'd2) m_rl = d;
        if (wa && a[2:0] == 3'd3) m_tl = d;
        @(negedge clk);
    endtask

    task automatic idle();                      cyc(1, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic hwr(logic [7:0] a, logic [7:0] d); cyc(0, a, 1, 0, d, 0, 0, 0); endtask
    task automatic hrd(logic [7:0] a);          cyc(0, a, 0, 1, 0, 0, 0, 0); endtask
    task automatic rxp(logic [7:0] d);          cyc(1, 0, 0, 0, 0, 1, d, 0); endtask
    task automatic txp();                       cyc(1, 0, 0, 0, 0, 0, 0, 1); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state read back through registers.
        tag = "R2";
        idle(); hrd(1); hrd(2); hrd(3); hrd(4); hrd(5); hrd(6); hrd(0);

        // R3 legacy receive levels: fill past 60 while stepping codes.
        tag = "R3";
        for (int i = 0; i < 62; i++) rxp(8'(i + 3));
        for (int c = 0; c < 4; c++) begin hwr(1, 8'(c << 4)); hrd(4); end
        // R11: drain below each level, data in order.
        tag = "R11";
        for (int i = 0; i < 62; i++) hrd(0);
        hrd(0);

        // R1 / R6: fill the transmit FIFO past full with each legacy code.
        tag = "R1";
        hwr(1, 8'h40);
        for (int i = 0; i < 130; i++) hwr(0, 8'(8'hA0 + i));
        hrd(6); hrd(4);
        tag = "R6";
        for (int i = 0; i < 70; i++) txp();
        hwr(1, 8'hC0);
        for (int i = 0; i < 60; i++) txp();

        // R4: extended levels 0, 5, 128, 200.
        tag = "R4";
        hwr(1, 8'h01);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] v;
            v = (k == 0) ? 8'd0 : (k == 1) ? 8'd5 : (k == 2) ? 8'd128 : 8'd200;
            hwr(2, v); hwr(3, v); hrd(2);
            for (int i = 0; i < 6; i++) rxp(8'(i));
            hwr(1, 8'h03);
            for (int i = 0; i < 6; i++) hwr(0, 8'(i));
            hwr(1, 8'h05);
        end

        // R8: overrun on full receive FIFO, sticky until status read.
        tag = "R8";
        for (int i = 0; i < 130; i++) rxp(8'(i));
        idle(); hrd(4); hrd(4);
        hrd(5);
        cyc(0, 8'h04, 0, 1, 0, 1, 8'h55, 0);  // read and new overrun together
        hrd(4); hrd(4);

        // R9: clear receive only; settings kept.
        tag = "R9";
        hwr(1, 8'h23);
        hrd(5); hrd(1); hrd(2);
        for (int i = 0; i < 10; i++) hwr(0, 8'(i));
        cyc(0, 8'h01, 1, 0, 8'h25, 0, 0, 1);   // clear TX alongside a pop
        hrd(6); hrd(1);

        // R7: unselected patterns ignore writes and keep the bus idle.
        tag = "R7";
        for (int p = 0; p < 3; p++) begin
            logic c; logic [7:0] a;
            c = (p == 0); a = (p == 1) ? 8'h40 : (p == 2) ? 8'h80 : 8'h00;
            cyc(c, a, 1, 0, 8'h77, 0, 0, 0);
            cyc(c, a | 8'h01, 1, 0, 8'hF9, 0, 0, 0);
            cyc(c, a | 8'h02, 1, 0, 8'h09, 0, 0, 0);
            cyc(c, a | 8'h04, 0, 1, 0, 0, 0, 0);
        end
        hrd(6); hrd(1); hrd(2);

        // R10: software reset with data in both FIFOs and an overrun.
        tag = "R10";
        for (int i = 0; i < 129; i++) rxp(8'(i));
        for (int i = 0; i < 20; i++) hwr(0, 8'(i));
        hwr(1, 8'hF9);
        hrd(1); hrd(4); hrd(5); hrd(6); hrd(2); hrd(3);
        idle();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (%s) actual=running expected=finished", tag);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule